// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the shared time base of a two-channel PWM generator. It holds one 16-bit counter and one period register that both channels use. A control word selects one of four counting modes, how a debug halt request is honoured, and whether a period write takes effect at once or waits for the next zero crossing. Two 3-bit fields set a prescaler that turns the system clock into counting steps.

The counter value, a zero-match pulse, a period-match pulse and the current counting direction are registered outputs. Downstream compare and action logic uses them to build the two waveforms. Software programs the block through a one-word write port with two addresses.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter reads 0, both event outputs are low, the direction output is 0, the control word is 0x0003 (freeze) and the active and buffered periods are 0. The counter does not move until the control word is written.
- R2: Up mode (control bits 1:0 = 00) counts 0, 1 … P and then wraps to 0, where P is the active period. The zero event is high for one cycle each time a step lands on 0. The period event is high for one cycle each time a step lands on P. The direction output is 0.
- R3: Down mode (bits 1:0 = 01) decrements by one per step and reloads P after 0. Events are raised as in R2, and the direction output is 1.
- R4: Up-down mode (bits 1:0 = 10) rises to P, then falls to 0, and repeats. The direction output becomes 1 on the step that lands on P and 0 on the step that lands on 0. Each turnaround raises exactly one event of the matching kind.
- R5: Freeze mode (bits 1:0 = 11) holds the counter and raises no events, including when it is entered while counting.
- R6: When control bit 3 is 1, a period write updates the active period on the next edge. When it is 0, only the buffered period is written, and it is copied to the active period on the step that lands on 0.
- R7: One step occurs every D clock cycles, with D = 2^C × (H = 0 ? 1 : 2H), where C is control bits 12:10 and H is bits 9:7. A control write restarts the prescaler, so the first step lands exactly D cycles after the write edge. No step occurs between ticks.
- R8: With control bits 15:14 = 1x, the halt input has no effect on counting.
- R9: With bits 15:14 = 00, while halt is high the counter makes at most one more step and then holds.
- R10: With bits 15:14 = 01, while halt is high the counter keeps stepping until it reads 0 and then holds there.
- R11: The counter and period cover the full 16-bit range. A down-mode step from 0 with P = 0xFFFF lands on 0xFFFF and raises the period event.
- R12: Write address 0 selects the control word and address 1 the period. A period write leaves the control word, and therefore the mode, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Write address: 0 control, 1 period |
| cfg_wdata | input | 16 | Write data |
| halt_req | input | 1 | Debug halt request |
| cnt_o | output | 16 | Current counter value |
| zero_evt_o | output | 1 | One-cycle pulse when a step lands on 0 |
| prd_evt_o | output | 1 | One-cycle pulse when a step lands on the period |
| dir_dn_o | output | 1 | 1 while counting down |

## Verification
The hardest situations to reach are the debug-halt ones, because their outcome depends on where the counter stands when halt rises. The bench makes this deterministic. It resets, loads the period immediately while frozen, then starts counting with a single control write. It raises halt on a known cycle after that write, so the expected hold value (one step later for R9, the next zero for R10) is fixed in advance. The buffered period is reached the same way: a second period value is written while frozen, so the change to the new period must appear exactly after the first wrap.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    localparam int CTRL_W     = 16;
    localparam int DIV_FLD_W  = 3;

    typedef enum logic [1:0] {
        CM_UP     = 2'b00,
        CM_DOWN   = 2'b01,
        CM_UPDN   = 2'b10,
        CM_FREEZE = 2'b11
    } cnt_mode_e;

    // run field: 00 stop after one more step, 01 stop at zero, 1x ignore halt
    localparam logic [1:0] RUN_STOP_NEXT  = 2'b00;
    localparam logic [1:0] RUN_STOP_CYCLE = 2'b01;

    typedef struct packed {
        logic [1:0]           run;
        logic                 rsv13;
        logic [DIV_FLD_W-1:0] clkdiv;
        logic [DIV_FLD_W-1:0] hsdiv;
        logic [2:0]           rsv6_4;
        logic                 prd_imm;
        logic                 rsv2;
        cnt_mode_e            mode;
    } tb_ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0003;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_PRD  = 1'b1;

endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] clkdiv,
    input  logic [DIV_W-1:0] hsdiv,
    output logic             tick
);
    localparam int FLD_MAX = (1 << DIV_W) - 1;
    localparam int PS_MAX  = (2 * FLD_MAX) << FLD_MAX;
    localparam int PS_W    = $clog2(PS_MAX + 1);

    logic [PS_W-1:0] pcnt_d, pcnt_q;
    logic [PS_W-1:0] hs_fac, div_val, limit;

    always_comb begin
        hs_fac  = (hsdiv == '0) ? PS_W'(1) : PS_W'({hsdiv, 1'b0});
        div_val = hs_fac << clkdiv;
        limit   = div_val - PS_W'(1);
        tick    = (pcnt_q >= limit);
        pcnt_d  = (restart || tick) ? '0 : pcnt_q + PS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    input  logic             imm,
    input  logic             load_zero,
    output logic [CNT_W-1:0] prd
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } prd_state_t;

    prd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_zero) st_d.active = st_q.shadow;
        if (wr_en) begin
            st_d.shadow = wdata;
            if (imm) st_d.active = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prd = st_q.active;
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic [1:0]       run,
    input  logic             halt,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_dn,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             load_zero
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_dn;
        logic             zero;
        logic             prd;
        logic             used;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] nxt;
    logic             nxt_dn, hold, step;

    always_comb begin
        hold = 1'b0;
        if (halt && !run[1]) begin
            if (run == RUN_STOP_NEXT)  hold = st_q.used;
            if (run == RUN_STOP_CYCLE) hold = (st_q.cnt == '0);
        end
        step = tick && (mode != CM_FREEZE) && !hold;

        nxt    = st_q.cnt;
        nxt_dn = st_q.dir_dn;
        unique case (mode)
            CM_UP: begin
                nxt    = (st_q.cnt >= prd) ? '0 : st_q.cnt + ONE;
                nxt_dn = 1'b0;
            end
            CM_DOWN: begin
                nxt    = (st_q.cnt == '0) ? prd : st_q.cnt - ONE;
                nxt_dn = 1'b1;
            end
            CM_UPDN: begin
                if (!st_q.dir_dn)
                    nxt = (st_q.cnt >= prd) ? ((st_q.cnt == '0) ? '0 : st_q.cnt - ONE)
                                            : st_q.cnt + ONE;
                else
                    nxt = (st_q.cnt == '0) ? ((prd == '0) ? '0 : ONE)
                                           : st_q.cnt - ONE;
                if (nxt == '0)      nxt_dn = 1'b0;
                else if (nxt >= prd) nxt_dn = 1'b1;
            end
            default: begin
                nxt    = st_q.cnt;
                nxt_dn = st_q.dir_dn;
            end
        endcase

        st_d      = st_q;
        st_d.zero = step && (nxt == '0);
        st_d.prd  = step && (nxt == prd);
        st_d.used = halt && (st_q.used || step);
        if (step) begin
            st_d.cnt    = nxt;
            st_d.dir_dn = nxt_dn;
        end
        load_zero = step && (nxt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign dir_dn   = st_q.dir_dn;
    assign zero_evt = st_q.zero;
    assign prd_evt  = st_q.prd;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             halt_req,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_evt_o,
    output logic             prd_evt_o,
    output logic             dir_dn_o
);
    tb_ctrl_t         ctrl_d, ctrl_q;
    logic             ctrl_wr, prd_wr, ps_tick, load_zero;
    logic [CNT_W-1:0] prd_active;

    always_comb begin
        ctrl_wr = cfg_we && (cfg_addr == ADDR_CTRL);
        prd_wr  = cfg_we && (cfg_addr == ADDR_PRD);
        ctrl_d  = ctrl_q;
        if (ctrl_wr) ctrl_d = tb_ctrl_t'(CTRL_W'(cfg_wdata));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= tb_ctrl_t'(CTRL_RESET);
        else        ctrl_q <= ctrl_d;
    end

    pwm_tb_prescale #(.DIV_W(DIV_FLD_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .clkdiv  (ctrl_q.clkdiv),
        .hsdiv   (ctrl_q.hsdiv),
        .tick    (ps_tick)
    );

    pwm_tb_period #(.CNT_W(CNT_W)) u_prd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prd_wr),
        .wdata     (cfg_wdata),
        .imm       (ctrl_q.prd_imm),
        .load_zero (load_zero),
        .prd       (prd_active)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ps_tick),
        .mode      (ctrl_q.mode),
        .run       (ctrl_q.run),
        .halt      (halt_req),
        .prd       (prd_active),
        .cnt       (cnt_o),
        .dir_dn    (dir_dn_o),
        .zero_evt  (zero_evt_o),
        .prd_evt   (prd_evt_o),
        .load_zero (load_zero)
    );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_addr,
    input logic [CNT_W-1:0] cfg_wdata,
    input logic             halt_req,
    input logic [15:0]      ctrl_bits,
    input logic             ps_tick,
    input logic [CNT_W-1:0] prd_active,
    input logic [CNT_W-1:0] cnt_o,
    input logic             zero_evt_o,
    input logic             prd_evt_o,
    input logic             dir_dn_o
);
    logic [1:0] mode, run;
    assign mode = ctrl_bits[1:0];
    assign run  = ctrl_bits[15:14];

    AST_ZERO_EVT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt_o |-> (cnt_o == '0)); // R2

    AST_PRD_EVT_AT_PRD: assert property (@(posedge clk) disable iff (!rst_n)
        prd_evt_o |-> (cnt_o == $past(prd_active))); // R2

    AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && ps_tick && !halt_req) |=> !dir_dn_o); // R2

    AST_DOWN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && ps_tick && !halt_req) |=> dir_dn_o); // R3

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> ($stable(cnt_o) && !zero_evt_o && !prd_evt_o)); // R5

    AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr && ctrl_bits[3]) |=> (prd_active == $past(cfg_wdata))); // R6

    AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_tick |=> ($stable(cnt_o) && !zero_evt_o && !prd_evt_o)); // R7

    AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run == 2'b01 && halt_req && cnt_o == '0) |=> $stable(cnt_o)); // R10
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .halt_req   (halt_req),
    .ctrl_bits  (ctrl_q),
    .ps_tick    (ps_tick),
    .prd_active (prd_active),
    .cnt_o      (cnt_o),
    .zero_evt_o (zero_evt_o),
    .prd_evt_o  (prd_evt_o),
    .dir_dn_o   (dir_dn_o)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic         cfg_addr = 1'b0;
    logic [W-1:0] cfg_wdata = '0;
    logic         halt_req = 1'b0;
    logic [W-1:0] cnt_o;
    logic         zero_evt_o, prd_evt_o, dir_dn_o;

    always #4 clk = ~clk;

    pwm_timebase #(.CNT_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .halt_req   (halt_req),
        .cnt_o      (cnt_o),
        .zero_evt_o (zero_evt_o),
        .prd_evt_o  (prd_evt_o),
        .dir_dn_o   (dir_dn_o)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         z;
        logic         p;
        logic         d;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int n_vec = 0;
    int n_bad = 0;

    task automatic push1(input int c, input bit z, input bit p, input bit d, input string tag);
        exp_t e;
        e.cnt = W'(c); e.z = z; e.p = p; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: one expected item per cycle, sampled 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (cnt_o !== e.cnt || zero_evt_o !== e.z || prd_evt_o !== e.p || dir_dn_o !== e.d) begin
                    n_bad++;
                    $display("FAIL %s: cnt/zero/prd/dir actual %h/%b/%b/%b expected %h/%b/%b/%b",
                             e.tag, cnt_o, zero_evt_o, prd_evt_o, dir_dn_o, e.cnt, e.z, e.p, e.d);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; halt_req = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input bit a, input logic [W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // reset, load period immediately while frozen, then start with one control write
    task automatic start(input logic [W-1:0] word, input logic [W-1:0] p);
        do_reset();
        wr(1'b0, 16'h000B);
        wr(1'b1, p);
        wr(1'b0, word);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    // expected sequences from the mode definitions, starting at 0 counting up
    task automatic push_run(input int mode, input int p, input int n, input string tag);
        int c = 0;
        bit dn = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (mode == 0) begin
                c = (c >= p) ? 0 : c + 1; dn = 1'b0;
            end else if (mode == 1) begin
                c = (c == 0) ? p : c - 1; dn = 1'b1;
            end else begin
                if (!dn) c = c + 1; else c = c - 1;
                if (c == p) dn = 1'b1; else if (c == 0) dn = 1'b0;
            end
            push1(c, c == 0, c == p, dn, tag);
        end
    endtask

    task automatic push_div(input int div, input int n);
        for (int k = 1; k <= n; k++) push1(k / div, 1'b0, 1'b0, 1'b0, "R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, frozen until configured
        do_reset();
        n_vec++;
        if (cnt_o !== '0 || zero_evt_o !== 1'b0 || prd_evt_o !== 1'b0 || dir_dn_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: cnt/zero/prd/dir actual %h/%b/%b/%b expected 0000/0/0/0",
                     cnt_o, zero_evt_o, prd_evt_o, dir_dn_o);
        end
        for (int k = 0; k < 4; k++) push1(0, 1'b0, 1'b0, 1'b0, "R1");
        drain();

        // R2: up mode, period 4
        start(16'h8008, 16'd4);
        push_run(0, 4, 12, "R2");
        drain();

        // R3: down mode, period 3
        start(16'h8009, 16'd3);
        push_run(1, 3, 10, "R3");
        drain();

        // R4: up-down mode, period 3
        start(16'h800A, 16'd3);
        push_run(2, 3, 14, "R4");
        drain();

        // R11: full-range period in down mode
        start(16'h8009, 16'hFFFF);
        push_run(1, 65535, 4, "R11");
        drain();

        // R5: freeze entered mid-run
        start(16'h8008, 16'd4);
        push1(1, 0, 0, 0, "R5"); push1(2, 0, 0, 0, "R5");
        for (int k = 0; k < 4; k++) push1(2, 0, 0, 0, "R5");
        wr(1'b0, 16'h800B);
        drain();

        // R6 / R12: buffered period takes effect after the first wrap
        do_reset();
        wr(1'b0, 16'h800B);
        wr(1'b1, 16'd5);
        wr(1'b0, 16'h8003);
        wr(1'b1, 16'd2);
        push1(0, 0, 0, 0, "R12"); push1(0, 0, 0, 0, "R12");
        wr(1'b0, 16'h8000);
        push1(1, 0, 0, 0, "R6"); push1(2, 0, 0, 0, "R6"); push1(3, 0, 0, 0, "R6");
        push1(4, 0, 0, 0, "R6"); push1(5, 0, 1, 0, "R6"); push1(0, 1, 0, 0, "R6");
        for (int k = 0; k < 2; k++) begin
            push1(1, 0, 0, 0, "R6"); push1(2, 0, 1, 0, "R6"); push1(0, 1, 0, 0, "R6");
        end
        drain();

        // R7: prescaler ratios 12, 4 and 2
        start(16'h8588, 16'hFFFF);
        push_div(12, 36);
        drain();
        start(16'h8808, 16'hFFFF);
        push_div(4, 12);
        drain();
        start(16'h8088, 16'hFFFF);
        push_div(2, 8);
        drain();

        // R8: free run ignores halt
        start(16'h8008, 16'd4);
        push_run(0, 4, 8, "R8");
        @(negedge clk); halt_req = 1'b1;
        drain();

        // R9: stop after the next step
        start(16'h0008, 16'd4);
        push1(1, 0, 0, 0, "R9"); push1(2, 0, 0, 0, "R9");
        for (int k = 0; k < 4; k++) push1(2, 0, 0, 0, "R9");
        @(negedge clk); halt_req = 1'b1;
        drain();

        // R10: stop when the counter returns to zero
        start(16'h4008, 16'd4);
        push1(1, 0, 0, 0, "R10"); push1(2, 0, 0, 0, "R10"); push1(3, 0, 0, 0, "R10");
        push1(4, 0, 1, 0, "R10"); push1(0, 1, 0, 0, "R10");
        for (int k = 0; k < 3; k++) push1(0, 0, 0, 0, "R10");
        @(negedge clk); halt_req = 1'b1;
        drain();
        halt_req = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule